// File: doc/BRIEF.md
# Toggle-Handshake Block Sender

This block streams a fixed-length byte buffer out of local memory to a peer across a pair of plain registers: one holds the data byte, the other holds the sender's ready flag. It runs no request/acknowledge pulse pair. Instead, flow control uses two level flags. The receiver asks for another byte by making its ready flag differ from the sender's. The receiver can also hold a separate busy level that pauses the stream, for example while it is away on other work.

A start pulse loads a base address. The sender then waits until the receiver is not busy and the two ready flags differ. It reads one byte from memory, places it in the data register, and only afterwards copies the receiver's ready level into its own ready flag. This acknowledges the byte. After 793 bytes at consecutive addresses it pulses done for one cycle and goes idle. The receiver flags come from another clock domain and are resynchronised before use.

Top module: `hs_block_sender`

## Requirements
- R1: After reset, `data_o` is 0, `sready_o` is 0, and `mem_rd_o` and `done_o` are low.
- R2: A transfer issues exactly LEN (793) single-cycle memory reads, at addresses base, base+1, … base+792. Each byte is returned one cycle after its read, and each one appears on `data_o` in order.
- R3: No memory read is issued while `rx_busy_i` has been high long enough to pass the synchronizer. A read is only allowed if `rx_busy_i` was low three clock samples earlier.
- R4: A byte is fetched only while the synchronized `rx_ready_i` differs from `sready_o`. When the two are equal, the sender stays silent.
- R5: When `sready_o` changes, it takes the level that `rx_ready_i` had at the synchronizer input three samples earlier. After each byte, the two flags are therefore equal.
- R6: `data_o` is loaded in the cycle before `sready_o` toggles. A `sready_o` change always follows a read issued three cycles earlier.
- R7: `done_o` is high for exactly one cycle after the final byte's acknowledge. The block then returns to idle and accepts a new start with a new base.
- R8: A start pulse during an active transfer is ignored. Address order and byte count continue from the original base.
- R9: While idle with no start, no memory read occurs, even if the ready flags differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, sampled only when idle |
| base_addr_i | input | AW | First buffer address, captured at start |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data, valid one cycle after `mem_rd_o` |
| data_o | output | DW | Data register seen by the receiver |
| sready_o | output | 1 | Sender ready flag |
| rx_busy_i | input | 1 | Receiver busy level (asynchronous) |
| rx_ready_i | input | 1 | Receiver ready flag (asynchronous) |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situation to reach is a receiver that raises busy or toggles ready just as the synchronizer is carrying an older level. The stale value is still in flight, so the sender could act on it. The bench drives a receiver model that toggles its ready flag only after observing the acknowledge. Mid-buffer, it holds busy while also presenting a pending request. It also fires a second start in the middle of a transfer. This covers paused and resumed streams as well as the ignored-start case. The checker relates every read and every flag change to the input levels three samples back.

// File: rtl/hs_sender_pkg.sv
package hs_sender_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_DATA,
    ST_FLAG,
    ST_DONE
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hs_xfer_ctr.sv
module hs_xfer_ctr #(
  parameter int AW  = 16,
  parameter int LEN = 793,
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_o <= base_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      addr_o <= addr_o + 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/hs_block_sender.sv
module hs_block_sender
  import hs_sender_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int LEN = 793
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] data_o,
  output logic          sready_o,
  input  logic          rx_busy_i,
  input  logic          rx_ready_i,
  output logic          done_o
);
  hs_state_e state_q, state_d;
  logic      busy_s, rdy_s, last;
  logic      load, step;

  hs_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rx_busy_i, rx_ready_i}),
    .q_o    ({busy_s, rdy_s})
  );

  assign load = (state_q == ST_IDLE) && start_i;
  assign step = (state_q == ST_FLAG);

  hs_xfer_ctr #(.AW(AW), .LEN(LEN)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (base_addr_i),
    .step_i (step),
    .addr_o (mem_addr_o),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_WAIT;
      ST_WAIT: if (!busy_s && (rdy_s != sready_o)) state_d = ST_READ;
      ST_READ: state_d = ST_DATA;
      ST_DATA: state_d = ST_FLAG;
      ST_FLAG: state_d = last ? ST_DONE : ST_WAIT;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      data_o   <= '0;
      sready_o <= 1'b0;
    end else begin
      state_q <= state_d;
      // data register first, flag one cycle later
      if (state_q == ST_DATA) data_o   <= mem_rdata_i;
      if (state_q == ST_FLAG) sready_o <= rdy_s;
    end
  end

  assign mem_rd_o = (state_q == ST_READ);
  assign done_o   = (state_q == ST_DONE);
endmodule

// File: rtl/hs_sender_chk.sv
module hs_sender_chk #(
  parameter int LEN = 793
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mem_rd_o,
  input logic sready_o,
  input logic rx_busy_i,
  input logic rx_ready_i,
  input logic done_o
);
  logic [15:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rd_cnt_q <= '0;
    else if (done_o)   rd_cnt_q <= '0;
    else if (mem_rd_o) rd_cnt_q <= rd_cnt_q + 1'b1;

  // R2
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  // R2
  read_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_cnt_q == 16'(LEN));

  // R3
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !$past(rx_busy_i, 3));

  // R4
  ready_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> $past(rx_ready_i, 3) != sready_o);

  // R5
  flag_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sready_o != $past(sready_o)) |-> sready_o == $past(rx_ready_i, 3));

  // R6
  data_before_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sready_o != $past(sready_o)) |-> $past(mem_rd_o, 3));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !mem_rd_o);
endmodule

bind hs_block_sender hs_sender_chk #(.LEN(LEN)) i_hs_sender_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_rd_o   (mem_rd_o),
  .sready_o   (sready_o),
  .rx_busy_i  (rx_busy_i),
  .rx_ready_i (rx_ready_i),
  .done_o     (done_o)
);

// File: tb/test_hs_block_sender.sv
module test_hs_block_sender;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int LEN = 793;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] data;
  logic          sready;
  logic          rx_busy = 1'b0;
  logic          rx_ready = 1'b0;
  logic          done;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  int addr_err = 0;
  int done_cnt = 0;
  int done_wide = 0;
  logic [AW-1:0] exp_addr = '0;
  logic done_prev = 1'b0;

  always #2 clk = ~clk;

  hs_block_sender #(.AW(AW), .DW(DW), .LEN(LEN)) i_hs_block_sender (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .base_addr_i (base),
    .mem_rd_o    (mem_rd),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .data_o      (data),
    .sready_o    (sready),
    .rx_busy_i   (rx_busy),
    .rx_ready_i  (rx_ready),
    .done_o      (done)
  );

  function automatic logic [DW-1:0] mem_fn(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

  // monitor at negedge
  always @(negedge clk) begin
    if (mem_rd) begin
      if (mem_addr != exp_addr) addr_err++;
      exp_addr <= exp_addr + 1'b1;
      rd_cnt++;
    end
    if (done) done_cnt++;
    if (done && done_prev) done_wide++;
    done_prev <= done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [AW-1:0] b);
    @(negedge clk);
    base  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // receiver: request one byte, wait for ack, return data
  task automatic get_byte(output logic [DW-1:0] b, output bit ok);
    ok = 1'b0;
    rx_ready = ~rx_ready;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (sready == rx_ready) begin ok = 1'b1; break; end
    end
    b = data;
  endtask

  task automatic t_reset;
    chk(data == '0, "R1 data", data, 0);
    chk(sready == 1'b0, "R1 sready", sready, 0);
    chk(!mem_rd && !done, "R1 strobes", {mem_rd, done}, 0);
  endtask

  task automatic t_idle_quiet;
    int r0 = rd_cnt;
    @(negedge clk);
    rx_ready = ~rx_ready;
    repeat (20) @(negedge clk);
    chk(rd_cnt == r0, "R9 idle reads", rd_cnt - r0, 0);
    rx_ready = sready;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_transfer(input logic [AW-1:0] b, input bit do_busy, input bit do_restart);
    int err = 0;
    int timeouts = 0;
    int d0 = done_cnt;
    logic [DW-1:0] got;
    bit ok;
    exp_addr = b;
    rd_cnt = 0;
    addr_err = 0;
    pulse_start(b);
    // R4: flags equal after start, nothing read
    repeat (10) @(negedge clk);
    chk(rd_cnt == 0, "R4 no request no read", rd_cnt, 0);
    for (int i = 0; i < LEN; i++) begin
      if (do_busy && i == 300) begin
        int r0 = rd_cnt;
        int s0 = sready;
        rx_busy = 1'b1;
        repeat (3) @(negedge clk);
        rx_ready = ~rx_ready;
        repeat (40) @(negedge clk);
        chk(rd_cnt == r0, "R3 busy blocks reads", rd_cnt - r0, 0);
        chk(sready == s0, "R3 busy holds sready", sready, s0);
        rx_busy = 1'b0;
        rx_ready = ~rx_ready;
      end
      if (do_restart && i == 100) pulse_start(b + 16'h0400);
      get_byte(got, ok);
      if (!ok) timeouts++;
      if (got != mem_fn(b + AW'(i))) err++;
      if (i == 0) chk(got == mem_fn(b), "R6 data valid at ack", got, mem_fn(b));
    end
    repeat (8) @(negedge clk);
    chk(timeouts == 0, "R5 acks received", timeouts, 0);
    chk(err == 0, "R2 byte content", err, 0);
    chk(rd_cnt == LEN, do_restart ? "R8 read count" : "R2 read count", rd_cnt, LEN);
    chk(addr_err == 0, do_restart ? "R8 address order" : "R2 address order", addr_err, 0);
    chk(done_cnt - d0 == 1, "R7 done count", done_cnt - d0, 1);
    chk(done_wide == 0, "R7 done width", done_wide, 0);
    chk(sready == rx_ready, "R5 flags equal", sready, rx_ready);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_idle_quiet();
    t_transfer(16'h2000, 1'b0, 1'b0);
    t_transfer(16'h3F80, 1'b1, 1'b0);
    t_transfer(16'h1234, 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule